// File: doc/BRIEF.md
# Microcontroller Internal Data Space Decoder

This block sits between an 8-bit microcontroller core and its internal data space. The core issues one access per request. Each request carries an 8-bit address, an access mode, a read/write flag and write data. The block works out whether the access lands in the 256-byte scratchpad RAM, which it holds itself, or in the special-function-register (SFR) space, which it reaches through a simple strobe port. It then performs the access and returns read data.

The upper half of the address range, 80h to FFh, is shared by two spaces, and the access mode decides which one is used:
- A direct reference to these addresses is an SFR access.
- An indirect reference reaches the upper 128 bytes of RAM.

The block also handles working-register references. Each of the four register banks holds eight bytes in low RAM, and a 2-bit bank number taken from the core's status word picks the active bank. For pointer accesses, the block fetches the pointer from register 0 or register 1 itself.

Single-bit accesses map onto a 16-byte RAM window or onto the SFRs whose address ends in hex 0 or 8. A bit write is carried out as a read followed by a write of the merged byte.

Mode codes on `req_mode`:

| Code | Mode |
|---|---|
| 0 | direct |
| 1 | indirect with a supplied address |
| 2 | bit |
| 3 | working register |
| 4 | indirect through R0/R1 |
| 5–7 | reserved |

A request is taken when `req_valid` and `req_ready` are both high at a rising clock edge.

Top module: `dsp_data_space`

## Requirements
- R1: In mode 0, addresses 00h–7Fh read and write RAM at the same byte address. Addresses 80h–FFh go to the SFR port at the same address and leave RAM untouched.
- R2: Mode 1 accesses RAM at the supplied address for all 256 addresses and never drives an SFR strobe. An indirect write to 80h–FFh does not change the SFR seen by a direct read of the same address.
- R3: In mode 3, `req_addr[2:0]` = n addresses RAM byte `stat_bank*8 + n`.
- R4: Mode 4 works in two steps:
  - In the accept cycle it reads the pointer from RAM byte `stat_bank*8 + req_addr[0]`.
  - In the following cycle `req_ready` is low, and the block reads or writes RAM (never an SFR) at the byte address held in that pointer.
  - Read data returns two cycles after acceptance.
- R5: In mode 2, bit address a < 80h selects RAM byte `20h + a[6:3]`, bit `a[2:0]`. Bit address a ≥ 80h selects SFR byte `{a[7:3],000}`, bit `a[2:0]`.
- R6: A bit read returns the selected bit in `rsp_rdata[0]`, with bits 7:1 zero.
- R7: A bit write stores `req_wdata[0]` into the selected bit and leaves the other seven bits unchanged. It takes two cycles:
  - In the accept cycle the block reads the target byte.
  - In the next cycle, with `req_ready` low, it writes the merged byte to the same address.
- R8: A read in modes 0–3 raises `rsp_valid` for exactly one cycle, one cycle after acceptance. Writes produce no response.
- R9: An SFR read whose reply carries `sfr_hit` low returns 00h. This applies to byte reads and to the source byte of a bit read or bit write.
- R10: Mode codes 5–7 cause no access, no strobe, no response and no state change.
- R11: During and right after reset, `req_ready` is high, and `rsp_valid`, `sfr_rd` and `sfr_wr` are low.
- R12: `sfr_rd` and `sfr_wr` are never high together, and `sfr_addr` is always 80h–FFh while either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_mode | input | 3 | Access mode code |
| req_addr | input | 8 | Byte, bit or register address |
| req_wdata | input | 8 | Write data; bit 0 is the bit value for bit writes |
| stat_bank | input | 2 | Active register bank from the status word |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| tgt_valid | output | 1 | An access is issued this cycle |
| tgt_wr | output | 1 | Issued access is a write |
| tgt_sfr | output | 1 | Issued access targets SFR space |
| tgt_bitop | output | 1 | Issued access belongs to a bit operation |
| tgt_addr | output | 8 | Physical byte address of the issued access |
| tgt_bit | output | 3 | Bit position for bit operations |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_addr | output | 8 | SFR byte address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, valid the cycle after `sfr_rd` |
| sfr_hit | input | 1 | SFR exists, valid with `sfr_rdata` |

## Verification
The hardest situation to reach is a chain of dependent state: a pointer access whose pointer was itself placed by a working-register write in a non-zero bank, and which points into the upper half of RAM. That is where the two meanings of 80h–FFh must stay apart.

The stimulus first fills the whole RAM through indirect writes so every byte is known. It then writes R0 and R1 of bank 2 through mode 3 and issues mode-4 reads and writes through them. After that it reads the pointed-to byte both indirectly and directly, so that the RAM and SFR copies of the same address are compared.

A long run of mixed random modes, banks and reserved codes follows, checked against a behavioural model. This exercises bit writes to SFRs that do not exist, where the merged byte must start from 00h.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    localparam int unsigned AW = 8;                 // data-space address width
    localparam int unsigned DW = 8;                 // byte width
    localparam int unsigned BW = $clog2(DW);        // bit index width
    localparam int unsigned NBANK_W = 2;            // register bank select width
    localparam int unsigned REG_W = 3;              // register index width

    typedef enum logic [2:0] {
        MODE_DIRECT   = 3'd0,
        MODE_INDIRECT = 3'd1,
        MODE_BIT      = 3'd2,
        MODE_REG      = 3'd3,
        MODE_PTR      = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_RMW  = 2'd2
    } state_e;

    // result of decoding one request
    typedef struct packed {
        logic          vld;
        logic          sfr;
        logic          bitop;
        logic          ptr;
        logic [AW-1:0] addr;
        logic [BW-1:0] bitp;
    } dec_t;

    // registered control state of the access sequencer
    typedef struct packed {
        state_e        st;
        logic          wr;
        logic [DW-1:0] wval;
        logic          src_sfr;
        logic [AW-1:0] addr;
        logic [BW-1:0] bitp;
        logic          rsp;
        logic          rsp_bit;
    } ctl_t;

    function automatic logic [DW-1:0] put_bit(input logic [DW-1:0] b,
                                              input logic [BW-1:0] p,
                                              input logic          v);
        logic [DW-1:0] r;
        r    = b;
        r[p] = v;
        return r;
    endfunction

endpackage

// File: rtl/dsp_decode.sv
module dsp_decode
    import dsp_pkg::*;
#(
    parameter logic [AW-1:0] BIT_RAM_BASE = 8'h20
) (
    input  logic [2:0]         mode,
    input  logic [AW-1:0]      addr,
    input  logic [NBANK_W-1:0] bank,
    output dec_t               dec
);

    localparam int unsigned WIN_W = AW - 1 - BW;   // bit-window byte index width

    always_comb begin
        dec      = '0;
        dec.bitp = addr[BW-1:0];
        case (mode)
            MODE_DIRECT: begin
                dec.vld  = 1'b1;
                dec.sfr  = addr[AW-1];
                dec.addr = addr;
            end
            MODE_INDIRECT: begin
                dec.vld  = 1'b1;
                dec.addr = addr;
            end
            MODE_BIT: begin
                dec.vld   = 1'b1;
                dec.bitop = 1'b1;
                if (addr[AW-1]) begin
                    dec.sfr  = 1'b1;
                    dec.addr = {addr[AW-1:BW], {BW{1'b0}}};
                end else begin
                    dec.addr = BIT_RAM_BASE + AW'(addr[BW+WIN_W-1:BW]);
                end
            end
            MODE_REG: begin
                dec.vld  = 1'b1;
                dec.addr = AW'({bank, addr[REG_W-1:0]});
            end
            MODE_PTR: begin
                dec.vld  = 1'b1;
                dec.ptr  = 1'b1;
                dec.addr = AW'({bank, {(REG_W-1){1'b0}}, addr[0]});
            end
            default: dec = '0;
        endcase
    end

endmodule

// File: rtl/dsp_ram.sv
module dsp_ram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb rdata_d = rd_en ? mem[addr] : rdata_q;

    always_ff @(posedge clk) begin
        rdata_q <= rdata_d;
        if (wr_en) mem[addr] <= wdata;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dsp_data_space.sv
module dsp_data_space
    import dsp_pkg::*;
#(
    parameter logic [AW-1:0] BIT_RAM_BASE = 8'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_wr,
    input  logic [2:0]         req_mode,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic [NBANK_W-1:0] stat_bank,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_rdata,
    output logic               tgt_valid,
    output logic               tgt_wr,
    output logic               tgt_sfr,
    output logic               tgt_bitop,
    output logic [AW-1:0]      tgt_addr,
    output logic [BW-1:0]      tgt_bit,
    output logic               sfr_rd,
    output logic               sfr_wr,
    output logic [AW-1:0]      sfr_addr,
    output logic [DW-1:0]      sfr_wdata,
    input  logic [DW-1:0]      sfr_rdata,
    input  logic               sfr_hit
);

    localparam ctl_t CTL_RST = '0;

    dec_t          dec;
    ctl_t          ctl_d, ctl_q;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] src_byte;
    logic [DW-1:0] t_wdata;

    dsp_decode #(.BIT_RAM_BASE(BIT_RAM_BASE)) u_decode (
        .mode (req_mode),
        .addr (req_addr),
        .bank (stat_bank),
        .dec  (dec)
    );

    dsp_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .rd_en (tgt_valid & ~tgt_wr & ~tgt_sfr),
        .wr_en (tgt_valid &  tgt_wr & ~tgt_sfr),
        .addr  (tgt_addr),
        .wdata (t_wdata),
        .rdata (ram_rdata)
    );

    // byte returned by the read issued last cycle; absent SFRs read as zero
    always_comb begin
        if (ctl_q.src_sfr) src_byte = sfr_hit ? sfr_rdata : '0;
        else               src_byte = ram_rdata;
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rsp = 1'b0;
        tgt_valid = 1'b0;
        tgt_wr    = 1'b0;
        tgt_sfr   = 1'b0;
        tgt_bitop = 1'b0;
        tgt_addr  = '0;
        tgt_bit   = '0;
        t_wdata   = '0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid && dec.vld) begin
                    tgt_valid     = 1'b1;
                    tgt_sfr       = dec.sfr;
                    tgt_bitop     = dec.bitop;
                    tgt_addr      = dec.addr;
                    tgt_bit       = dec.bitp;
                    ctl_d.src_sfr = dec.sfr;
                    ctl_d.addr    = dec.addr;
                    ctl_d.bitp    = dec.bitp;
                    ctl_d.wr      = req_wr;
                    ctl_d.wval    = req_wdata;
                    if (dec.ptr) begin
                        ctl_d.st = ST_PTR;
                    end else if (dec.bitop && req_wr) begin
                        ctl_d.st = ST_RMW;
                    end else begin
                        tgt_wr        = req_wr;
                        t_wdata       = req_wdata;
                        ctl_d.rsp     = ~req_wr;
                        ctl_d.rsp_bit = dec.bitop;
                    end
                end
            end
            ST_PTR: begin
                tgt_valid     = 1'b1;
                tgt_wr        = ctl_q.wr;
                tgt_addr      = ram_rdata;
                t_wdata       = ctl_q.wval;
                ctl_d.src_sfr = 1'b0;
                ctl_d.rsp     = ~ctl_q.wr;
                ctl_d.rsp_bit = 1'b0;
                ctl_d.st      = ST_IDLE;
            end
            ST_RMW: begin
                tgt_valid = 1'b1;
                tgt_wr    = 1'b1;
                tgt_sfr   = ctl_q.src_sfr;
                tgt_bitop = 1'b1;
                tgt_addr  = ctl_q.addr;
                tgt_bit   = ctl_q.bitp;
                t_wdata   = put_bit(src_byte, ctl_q.bitp, ctl_q.wval[0]);
                ctl_d.st  = ST_IDLE;
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign rsp_valid = ctl_q.rsp;
    assign rsp_rdata = ctl_q.rsp_bit ? DW'(src_byte[ctl_q.bitp]) : src_byte;
    assign sfr_rd    = tgt_valid & tgt_sfr & ~tgt_wr;
    assign sfr_wr    = tgt_valid & tgt_sfr &  tgt_wr;
    assign sfr_addr  = tgt_addr;
    assign sfr_wdata = t_wdata;

endmodule

// File: rtl/dsp_data_space_chk.sv
module dsp_data_space_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_mode,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       tgt_valid,
    input logic       tgt_wr,
    input logic       tgt_sfr,
    input logic       tgt_bitop,
    input logic [7:0] tgt_addr,
    input logic       sfr_rd,
    input logic       sfr_wr,
    input logic [7:0] sfr_addr
);

    // R12: strobes exclusive
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sfr_rd, sfr_wr}));

    // R12: SFR port only sees the upper half
    a_r12_sfr_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd || sfr_wr) |-> sfr_addr[7]);

    // R8: a response always follows an issued read
    a_r8_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(tgt_valid && !tgt_wr));

    // R7: merged write repeats the address read the cycle before
    a_r7_rmw_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && tgt_wr && tgt_bitop) |->
            ($past(tgt_valid && !tgt_wr && tgt_bitop) && tgt_addr == $past(tgt_addr) && !req_ready));

    // R4, R7: busy for one cycle at most
    a_r4_busy_one: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    // R5: SFR bit targets are 8-byte aligned
    a_r5_sfr_bit_align: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && tgt_bitop && tgt_sfr) |-> (tgt_addr[2:0] == 3'd0));

    // R10: reserved modes issue nothing
    a_r10_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_mode > 3'd4) |-> !tgt_valid);

    // R2: supplied-address indirect never targets SFRs
    a_r2_ind_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_mode == 3'd1) |-> !tgt_sfr);

    // R11: reset leaves the block idle
    a_r11_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid));

endmodule

bind dsp_data_space dsp_data_space_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .tgt_valid (tgt_valid),
    .tgt_wr    (tgt_wr),
    .tgt_sfr   (tgt_sfr),
    .tgt_bitop (tgt_bitop),
    .tgt_addr  (tgt_addr),
    .sfr_rd    (sfr_rd),
    .sfr_wr    (sfr_wr),
    .sfr_addr  (sfr_addr)
);

// File: tb/dsp_data_space_bench.sv
module dsp_data_space_bench;

    localparam int CLK_NS   = 10;
    localparam int WDOG_CYC = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_wr = 1'b0;
    logic [2:0] req_mode = '0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic [1:0] stat_bank = '0;
    logic       req_ready, rsp_valid;
    logic [7:0] rsp_rdata;
    logic       tgt_valid, tgt_wr, tgt_sfr, tgt_bitop;
    logic [7:0] tgt_addr;
    logic [2:0] tgt_bit;
    logic       sfr_rd, sfr_wr;
    logic [7:0] sfr_addr, sfr_wdata;
    logic [7:0] sfr_rdata = '0;
    logic       sfr_hit = 1'b0;

    dsp_data_space u_dsp_data_space (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
        .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
        .stat_bank(stat_bank), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .tgt_valid(tgt_valid), .tgt_wr(tgt_wr),
        .tgt_sfr(tgt_sfr), .tgt_bitop(tgt_bitop), .tgt_addr(tgt_addr),
        .tgt_bit(tgt_bit), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .sfr_hit(sfr_hit)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] m_ram [256];   // model RAM
    logic [7:0] m_sfr [128];   // model SFR contents
    logic [7:0] e_sfr [128];   // SFR environment storage

    typedef struct { int due; logic [7:0] data; string req; } exp_t;
    exp_t pend[$];

    function automatic bit sfr_impl(input logic [7:0] a);
        return !(a[1:0] == 2'b11 || a[6:3] == 4'hF);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // SFR environment: data one cycle after the read strobe
    always @(posedge clk) begin
        if (sfr_rd) begin
            sfr_hit   <= sfr_impl(sfr_addr);
            sfr_rdata <= sfr_impl(sfr_addr) ? e_sfr[sfr_addr[6:0]] : 8'hA5;
        end
        if (sfr_wr && sfr_impl(sfr_addr)) e_sfr[sfr_addr[6:0]] <= sfr_wdata;
    end

    // response comparison every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (pend.size() == 0) chk("R8", "unexpected response", 1, 0);
                else begin
                    exp_t e;
                    e = pend.pop_front();
                    chk(e.req, "response cycle", cyc, e.due);
                    chk(e.req, "response data", rsp_rdata, e.data);
                end
            end else if (pend.size() != 0 && pend[0].due <= cyc) begin
                exp_t e;
                e = pend.pop_front();
                chk(e.req, "response missing", 0, 1);
            end
        end
    end

    task automatic op(input logic [2:0] mode, input bit wr, input logic [7:0] a,
                      input logic [7:0] wd, input logic [1:0] bank);
        logic [7:0] ba, first, rd, nv;
        logic [2:0] bp;
        bit sfr, bitop, impl;
        string rq;
        int base_c;
        exp_t e;
        while (!req_ready) @(negedge clk);
        sfr = 0; bitop = 0; bp = a[2:0]; ba = a;
        case (mode)
            3'd0: begin sfr = a[7]; rq = "R1"; end
            3'd1: rq = "R2";
            3'd2: begin
                bitop = 1; rq = wr ? "R7" : "R6";
                if (a[7]) begin sfr = 1; ba = {a[7:3], 3'b000}; end
                else ba = 8'h20 + {4'b0000, a[6:3]};
            end
            3'd3: begin ba = {3'b000, bank, a[2:0]}; rq = "R3"; end
            3'd4: begin ba = m_ram[{3'b000, bank, 2'b00, a[0]}]; rq = "R4"; end
            default: rq = "R10";
        endcase
        first = (mode == 3'd4) ? {3'b000, bank, 2'b00, a[0]} : ba;
        impl  = sfr_impl(ba);
        rd    = sfr ? (impl ? m_sfr[ba[6:0]] : 8'h00) : m_ram[ba];
        nv    = rd;
        nv[bp] = wd[0];
        req_valid = 1; req_mode = mode; req_wr = wr; req_addr = a;
        req_wdata = wd; stat_bank = bank;
        base_c = cyc;
        #1;
        if (mode <= 3'd4) begin
            chk(rq, "tgt_valid", tgt_valid, 1);
            chk(rq, "tgt_sfr", tgt_sfr, sfr);
            chk(rq, "tgt_addr", tgt_addr, first);
            chk(rq, "tgt_bitop", tgt_bitop, bitop);
            if (bitop) chk("R5", "tgt_bit", tgt_bit, bp);
            if (!wr) begin
                e.due  = base_c + 1 + ((mode == 3'd4) ? 1 : 0);
                e.data = bitop ? {7'b0, rd[bp]} : rd;
                e.req  = (sfr && !impl) ? "R9" : rq;
                pend.push_back(e);
            end else begin
                if (bitop) rd = nv; else rd = wd;
                if (sfr) begin if (impl) m_sfr[ba[6:0]] = rd; end
                else m_ram[ba] = rd;
            end
        end else begin
            chk("R10", "tgt_valid", tgt_valid, 0);
            chk("R10", "sfr strobes", {sfr_rd, sfr_wr}, 0);
        end
        @(negedge clk);
        req_valid = 0;
        if (mode == 3'd4) begin
            chk("R4", "busy", req_ready, 0);
            chk("R4", "pointer addr", tgt_addr, ba);
            chk("R4", "pointer ram", tgt_sfr, 0);
            chk("R4", "pointer wr", tgt_wr, wr);
        end else if (mode == 3'd2 && wr) begin
            chk("R7", "busy", req_ready, 0);
            chk("R7", "merge wr", tgt_wr, 1);
            chk("R7", "merge addr", tgt_addr, ba);
            chk("R7", "merged data", sfr_wdata, nv);
        end else if (mode > 3'd4) begin
            chk("R10", "ready", req_ready, 1);
        end
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            m_sfr[i] = 8'(i) ^ 8'h5A;
            e_sfr[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        chk("R11", "ready in reset", req_ready, 1);
        chk("R11", "rsp in reset", rsp_valid, 0);
        chk("R11", "strobes in reset", {sfr_rd, sfr_wr}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R11", "ready after reset", req_ready, 1);
        chk("R11", "rsp after reset", rsp_valid, 0);

        // fill RAM through indirect writes
        for (int i = 0; i < 256; i++) op(3'd1, 1, 8'(i), 8'(i * 37 + 11), 2'd0);
        // R1 / R2 reads at the edges of both halves
        op(3'd0, 0, 8'h00, 0, 0); op(3'd0, 0, 8'h7F, 0, 0);
        op(3'd1, 0, 8'h80, 0, 0); op(3'd1, 0, 8'hFF, 0, 0);
        // R1 / R9 SFR reads, present and absent
        op(3'd0, 0, 8'h80, 0, 0); op(3'd0, 0, 8'h83, 0, 0);
        op(3'd0, 0, 8'hF8, 0, 0); op(3'd0, 0, 8'hD0, 0, 1);
        op(3'd0, 1, 8'h90, 8'h3C, 0); op(3'd0, 0, 8'h90, 0, 0);
        op(3'd0, 1, 8'h93, 8'h77, 0); op(3'd0, 0, 8'h93, 0, 0);
        // R2 separation of upper RAM and SFR
        op(3'd1, 1, 8'h90, 8'hC9, 0); op(3'd1, 0, 8'h90, 0, 0);
        op(3'd0, 0, 8'h90, 0, 0);
        // R3 bank selection
        for (int b = 0; b < 4; b++) op(3'd3, 1, 8'h05, 8'(8'hB0 + b), 2'(b));
        for (int b = 0; b < 4; b++) op(3'd0, 0, 8'(b * 8 + 5), 0, 0);
        op(3'd3, 0, 8'hFD, 0, 2'd3);
        // R4 pointer through R0/R1 of bank 2
        op(3'd3, 1, 8'h00, 8'hC3, 2'd2); op(3'd4, 0, 8'h00, 0, 2'd2);
        op(3'd3, 1, 8'h01, 8'h85, 2'd2); op(3'd4, 1, 8'h01, 8'h5E, 2'd2);
        op(3'd1, 0, 8'h85, 0, 0); op(3'd0, 0, 8'h85, 0, 0);
        op(3'd4, 0, 8'h01, 0, 2'd2); op(3'd4, 0, 8'h00, 0, 2'd1);
        // R5 / R6 / R7 bit operations
        op(3'd2, 1, 8'h00, 8'h01, 0); op(3'd2, 1, 8'h7F, 8'hFE, 0);
        op(3'd0, 0, 8'h20, 0, 0); op(3'd0, 0, 8'h2F, 0, 0);
        op(3'd2, 0, 8'h00, 0, 0); op(3'd2, 0, 8'h7F, 0, 0);
        op(3'd2, 1, 8'hD3, 8'h01, 0); op(3'd0, 0, 8'hD0, 0, 0);
        op(3'd2, 0, 8'hD3, 0, 0); op(3'd2, 1, 8'hFD, 8'h01, 0);
        op(3'd2, 0, 8'hFA, 0, 0);
        // R10 reserved modes leave state alone
        op(3'd5, 1, 8'h40, 8'hEE, 0); op(3'd6, 0, 8'h40, 0, 0);
        op(3'd7, 1, 8'h90, 8'hEE, 0);
        op(3'd0, 0, 8'h40, 0, 0); op(3'd0, 0, 8'h90, 0, 0);
        // mixed random traffic
        for (int i = 0; i < 600; i++)
            op(3'($urandom_range(0, 7)), bit'($urandom_range(0, 1)),
               8'($urandom), 8'($urandom), 2'($urandom_range(0, 3)));
        repeat (4) @(negedge clk);
        chk("R8", "all responses seen", pend.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule